// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a link to a 16-bit, single-channel serial analog-to-digital converter. The converter exposes one active-high convert line, a serial clock input and a serial data output. The convert line does two jobs. Its rising edge starts a conversion. Its falling edge puts the converter back into sampling and turns on the data output. While the line is high, that data output floats.

A conversion is launched by a one-cycle `start` request or by an internal rate tick when `auto_en` is set. The controller first drops the convert line for one SCK half-period so the converter can acquire. It then raises the line and holds it for `conv_cycles` clocks. Next it lowers the line again, waits one half-period, and produces exactly sixteen SCK pulses. Each bit is taken on a rising SCK edge, most significant bit first.

At the end of the read the controller returns SCK low and the convert line high. This leaves the converter in its low-power sleep state. In the same cycle it presents the straight-binary code with a one-cycle valid strobe. All timing values are run-time inputs counted in system-clock cycles, and each must be at least 1.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is applied and immediately after it, `adc_conv` is 1, `adc_sck` is 0, and `busy`, `data_valid` and `overrun` are 0.
- R2: A trigger accepted in idle drives `adc_conv` low for `half_cycles` clocks. It then holds `adc_conv` high for exactly `conv_cycles` clocks, and then drives it low again for the read.
- R3: The first rising SCK edge comes exactly `half_cycles` clocks after `adc_conv` falls to begin the read. Each SCK high and low phase lasts `half_cycles` clocks. SCK is never high while `adc_conv` is high.
- R4: `adc_sdo` is sampled in the clock edge that drives SCK high. The first bit taken is bit 15 and the last is bit 0.
- R5: Each conversion produces exactly 16 rising SCK edges. After the 16th bit, SCK stays low and `adc_conv` returns high until the next trigger.
- R6: `data` carries the captured word as unipolar straight binary, so any value from 0x0000 to 0xFFFF passes through unchanged. `data_valid` is high for exactly one cycle, in the cycle where `adc_conv` returns high. A trigger at edge t0 gives valid at edge t0 + `conv_cycles` + 33·`half_cycles`.
- R7: `busy` is 1 from the cycle after a trigger is accepted until the cycle in which `data_valid` rises, and is 0 in idle.
- R8: A `start` that arrives while busy is ignored and starts no extra conversion. `overrun` is high for the one following cycle. A `start` that is accepted in idle leaves `overrun` at 0.
- R9: With `auto_en` high, a trigger fires every `period_cycles` clocks, and the first one comes `period_cycles` clocks after `auto_en` rises. A tick that falls while busy is ignored and raises `overrun` in the same way as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle conversion request |
| auto_en | input | 1 | Enables free-running conversions |
| conv_cycles | input | CW (16) | Conversion wait in clocks, at least 1 |
| half_cycles | input | HW (8) | SCK half-period in clocks, at least 1 |
| period_cycles | input | PW (24) | Free-running trigger period in clocks |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Convert line, high = convert or sleep |
| adc_sck | output | 1 | Serial clock to the converter |
| data | output | NB (16) | Last captured code |
| data_valid | output | 1 | One-cycle strobe for a new `data` |
| busy | output | 1 | Conversion or read in progress |
| overrun | output | 1 | One-cycle pulse when a trigger was dropped |

## Verification
The bench drives a behavioural converter model. The model floats its output while the convert line is high, reloads its word on each falling edge of the convert line, and shifts in zeros on each falling SCK edge.

Codes at both ends of the range and patterns with alternating bits expose a capture on the wrong SCK edge, which would drop B15 and append a zero. They also expose a reversed bit order. The bench counts SCK rises per frame and watches the idle period after valid, so a seventeenth clock or an idle SCK would show up as an extra-bit or extra-edge mismatch.

The bench measures the convert-high width, the gap before the first SCK rise, the SCK high width and the trigger-to-valid latency. These catch off-by-one counter loads. Mid-frame start requests and a rate tick faster than a frame check that a dropped trigger still flags overrun and never restarts the frame.

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
  parameter int CW = 16,
  parameter int HW = 8,
  parameter int PW = 24,
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          auto_en,
  input  logic [CW-1:0] conv_cycles,
  input  logic [HW-1:0] half_cycles,
  input  logic [PW-1:0] period_cycles,
  input  logic          adc_sdo,
  output logic          adc_conv,
  output logic          adc_sck,
  output logic [NB-1:0] data,
  output logic          data_valid,
  output logic          busy,
  output logic          overrun
);
  localparam int TW = (CW > HW) ? CW : HW;
  localparam int BW = $clog2(NB + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACQ, S_CONV, S_GAP, S_SHIFT} state_t;

  state_t          st;
  logic [TW-1:0]   cnt;
  logic [BW-1:0]   nbits;
  logic [NB-1:0]   sh;
  logic [PW-1:0]   pcnt;

  wire           tick    = auto_en && (pcnt == period_cycles - 1'b1);
  wire           trig    = start || tick;
  wire           cnt_end = (cnt == '0);
  wire [TW-1:0]  half_ld = TW'(half_cycles) - 1'b1;
  wire [TW-1:0]  conv_ld = TW'(conv_cycles) - 1'b1;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n || !auto_en || tick) pcnt <= '0;
    else                            pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      adc_conv   <= 1'b1;
      adc_sck    <= 1'b0;
      cnt        <= '0;
      nbits      <= '0;
      sh         <= '0;
      data       <= '0;
      data_valid <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      data_valid <= 1'b0;
      overrun    <= trig && busy;
      case (st)
        S_IDLE: if (trig) begin
          st       <= S_ACQ;
          adc_conv <= 1'b0;
          cnt      <= half_ld;
        end
        S_ACQ: if (cnt_end) begin
          st       <= S_CONV;
          adc_conv <= 1'b1;
          cnt      <= conv_ld;
        end else cnt <= cnt - 1'b1;
        S_CONV: if (cnt_end) begin
          st       <= S_GAP;
          adc_conv <= 1'b0;
          cnt      <= half_ld;
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt_end) begin
          st      <= S_SHIFT;
          adc_sck <= 1'b1;
          sh      <= {sh[NB-2:0], adc_sdo};
          nbits   <= BW'(1);
          cnt     <= half_ld;
        end else cnt <= cnt - 1'b1;
        S_SHIFT: if (cnt_end) begin
          if (adc_sck) begin
            adc_sck <= 1'b0;
            cnt     <= half_ld;
            if (nbits == BW'(NB)) begin
              st         <= S_IDLE;
              adc_conv   <= 1'b1;
              data       <= sh;
              data_valid <= 1'b1;
            end
          end else begin
            adc_sck <= 1'b1;
            sh      <= {sh[NB-2:0], adc_sdo};
            nbits   <= nbits + 1'b1;
            cnt     <= half_ld;
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_conv,
  input logic adc_sck,
  input logic data_valid,
  input logic busy,
  input logic overrun
);
  // R3
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sck |-> (!adc_conv && busy));

  // R3
  sck_rise_conv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sck) |-> !$past(adc_conv));

  // R5
  idle_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (adc_conv && !adc_sck));

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);

  // R7
  valid_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (!busy && $past(busy) && adc_conv));

  // R8
  overrun_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy));
endmodule

bind adc_readout_ctrl adc_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adc_conv(adc_conv), .adc_sck(adc_sck),
  .data_valid(data_valid), .busy(busy), .overrun(overrun)
);

// File: tb/tb_adc_readout_ctrl.sv
module tb_adc_readout_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        auto_en = 1'b0;
  logic [15:0] conv_cycles = 16'd4;
  logic [7:0]  half_cycles = 8'd1;
  logic [23:0] period_cycles = 24'd100;
  wire         adc_sdo;
  logic        adc_conv, adc_sck, data_valid, busy, overrun;
  logic [15:0] data;

  always #5 clk = ~clk;

  adc_readout_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_en(auto_en),
    .conv_cycles(conv_cycles), .half_cycles(half_cycles),
    .period_cycles(period_cycles), .adc_sdo(adc_sdo), .adc_conv(adc_conv),
    .adc_sck(adc_sck), .data(data), .data_valid(data_valid), .busy(busy),
    .overrun(overrun)
  );

  // converter model
  logic [15:0] analog_code = 16'h0;
  logic [15:0] mdl_sr = 16'h0;
  logic        pc = 1'b1, ps = 1'b0;
  always @(adc_conv or adc_sck) begin
    if (pc && !adc_conv)      mdl_sr = analog_code;
    else if (ps && !adc_sck)  mdl_sr = {mdl_sr[14:0], 1'b0};
    pc = adc_conv;
    ps = adc_sck;
  end
  assign adc_sdo = adc_conv ? 1'bz : mdl_sr[15];

  // monitor
  int rises = 0, conv_run = 0, conv_len = 0, gap_run = 0, gap_len = 0;
  int sck_run = 0, sck_len = 0, valid_cnt = 0, ovr_cnt = 0;
  logic mconv = 1'b1, msck = 1'b0;
  always @(negedge clk) begin
    if (adc_sck && !msck) begin
      if (rises == 0) gap_len = gap_run;
      rises++;
    end
    if (adc_sck) sck_run++;
    else if (msck) begin sck_len = sck_run; sck_run = 0; end
    if (adc_conv) begin conv_run++; gap_run = 0; end
    else begin
      if (mconv) conv_len = conv_run;
      conv_run = 0;
      if (!adc_sck) gap_run++;
    end
    if (data_valid) valid_cnt++;
    if (overrun) ovr_cnt++;
    mconv = adc_conv;
    msck = adc_sck;
  end

  int compared = 0, mismatched = 0;
  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] code, input logic [15:0] c, input logic [7:0] h);
    int n;
    @(negedge clk);
    analog_code = code; conv_cycles = c; half_cycles = h;
    rises = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 busy after start", busy, 1);
    chk("R8 no overrun on accepted start", overrun, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!data_valid && n < 20000);
    chk("R6 data word", data, code);
    chk("R6 latency", n, c + 33 * h);
    chk("R5 sixteen sck rises", rises, 16);
    chk("R2 convert high width", conv_len, c);
    chk("R3 gap before first sck", gap_len, h);
    chk("R3 sck high width", sck_len, h);
    chk("R7 busy low at valid", busy, 0);
    chk("R4 conv high at valid", adc_conv, 1);
    @(negedge clk);
    chk("R6 valid one cycle", data_valid, 0);
  endtask

  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 16'd1,  8'd1},
    {16'hFFFF, 16'd5,  8'd2},
    {16'hA5C3, 16'd12, 8'd3},
    {16'h8001, 16'd3,  8'd1},
    {16'h0001, 16'd20, 8'd4},
    {16'h7FFE, 16'd7,  8'd2}
  };

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int v0;
    repeat (3) @(negedge clk);
    chk("R1 conv in reset", adc_conv, 1);
    chk("R1 sck in reset", adc_sck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 valid after reset", data_valid, 0);
    chk("R1 overrun after reset", overrun, 0);
    chk("R1 conv after reset", adc_conv, 1);

    for (int i = 0; i < NV; i++) frame(VEC[i][39:24], VEC[i][23:8], VEC[i][7:0]);

    // R5: no further edges once the frame is over
    rises = 0;
    repeat (30) @(negedge clk);
    chk("R5 no sck in idle", rises, 0);
    chk("R5 conv high in idle", adc_conv, 1);

    // R8: start while busy
    analog_code = 16'h3C5A; conv_cycles = 16'd10; half_cycles = 8'd2;
    v0 = valid_cnt;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk("R8 overrun pulse", overrun, 1);
    @(negedge clk);
    chk("R8 overrun one cycle", overrun, 0);
    repeat (200) @(negedge clk);
    chk("R8 ignored start adds no frame", valid_cnt - v0, 1);
    chk("R8 data intact", data, 16'h3C5A);

    // R9: free-running triggers
    analog_code = 16'hC001; conv_cycles = 16'd4; half_cycles = 8'd1;
    period_cycles = 24'd50;
    v0 = valid_cnt;
    ovr_cnt = 0;
    auto_en = 1'b1;
    repeat (150) @(negedge clk);
    chk("R9 two periodic frames", valid_cnt - v0, 2);
    chk("R9 no overrun at slow rate", ovr_cnt, 0);
    chk("R9 periodic data", data, 16'hC001);
    auto_en = 1'b0;
    repeat (80) @(negedge clk);

    // R9: tick faster than a frame
    period_cycles = 24'd10;
    v0 = valid_cnt;
    ovr_cnt = 0;
    auto_en = 1'b1;
    repeat (100) @(negedge clk);
    auto_en = 1'b0;
    repeat (80) @(negedge clk);
    chk("R9 fast tick raises overrun", ovr_cnt > 0, 1);
    chk("R9 fast tick frames complete", valid_cnt - v0 >= 1, 1);
    chk("R9 idle after disable", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule